// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a synchronous request port to an external asynchronous static RAM organised as 262,144 words of 16 bits. A requester presents a word address, a read/write flag, write data and a two-bit byte enable with a valid/ready handshake. The controller registers the request and then runs one external cycle. During that cycle it drives the active-low chip select, output enable, write enable and the two byte strobes. It also sets the direction of the shared data bus through an output-enable pin.

Every external timing limit is given as a parameter in nanoseconds, next to a clock-period parameter. The controller turns each limit into a number of clock-cycle wait states, rounding up, with at least one cycle per phase. After a read it leaves the bus idle for a turnaround gap, so the RAM's outputs have floated before anything else can drive the bus. Read data comes back on a one-cycle valid pulse. Byte lanes that were not enabled read back as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, req_ready is 1. In those cycles mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all 1, and mem_dq_oe and rd_valid are 0.
- R2: A request is taken on the rising edge where req_valid and req_ready are both 1. From the next cycle req_ready stays 0 until the external cycle ends, and for a read until the turnaround ends as well. While req_ready is 0, req_valid has no effect.
- R3: A read holds mem_cs_n and mem_oe_n at 0 and mem_we_n at 1, with mem_dq_oe at 0, for N_RD cycles. N_RD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_OE/CLK), and at least 1. The default parameters give 6.
- R4: rd_data is captured at the edge that ends the last read cycle. rd_valid is 1 for exactly one cycle, the first idle cycle after the turnaround, and rd_data holds its value until the next read. Bits 7:0 are the lower lane, enabled by req_be[0]. Bits 15:8 are the upper lane, enabled by req_be[1]. A lane that is not enabled returns 0.
- R5: During an external cycle, mem_lb_n is the inverse of req_be[0] and mem_ub_n is the inverse of req_be[1]. Whenever mem_cs_n is 1, both strobes are 1.
- R6: After a read, N_TURN = ceil(T_FLOAT/CLK) cycles follow (2 by default). In these cycles all controls are inactive, mem_dq_oe is 0 and req_ready is 0.
- R7: A write runs in three phases, all with mem_cs_n at 0 and mem_dq_oe at 1:
  - one setup cycle with mem_we_n at 1;
  - N_WP cycles with mem_we_n at 0, where N_WP is the largest of ceil(T_WP/CLK), ceil(T_DW/CLK), and ceil(max(T_AW,T_CW)/CLK)-1, and at least 1 (4 by default);
  - N_WR = max(1, ceil(T_WC/CLK)-1-N_WP) recovery cycles with mem_we_n at 1 (1 by default).
- R8: While mem_cs_n is 0, mem_addr equals the accepted address, and mem_dq_out equals the accepted write data whenever mem_dq_oe is 1. Both hold constant for the whole cycle.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0. mem_we_n is 0 only while mem_cs_n is 0 and mem_oe_n is 1.
- R10: A write changes only the byte lanes whose enable bit is 1. A write with req_be = 2'b00 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | 16 | Captured read word, disabled lanes zero |
| mem_addr | output | 18 | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_in | input | 16 | Data read from the RAM bus |

## Verification
The case hardest to reach from the ports is a request whose valid is already high in the one idle cycle that carries the read-data pulse. That request must be taken exactly there, and only after the turnaround gap. The stimulus keeps req_valid high through a whole read and then changes the fields to a write in that same cycle. The bench's reference model then shows whether the write was taken too early, taken twice, or drove the bus during the turnaround. The bus model feeds a fixed pattern on floating lanes, so any lane-masking error shows up in the returned word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_READ   = 3'd1,
    PH_TURN   = 3'd2,
    PH_WSETUP = 3'd3,
    PH_WPULSE = 3'd4,
    PH_WREC   = 3'd5
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Wait states for a limit: round up, never below one cycle.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  // The setup cycle already counts toward address/select-to-end-of-write.
  function automatic int wpulse_cyc(input int t_wp, input int t_dw, input int t_aw,
                                    input int t_cw, input int clk_ns);
    int lead;
    lead = imax(ns_to_cyc(t_aw, clk_ns), ns_to_cyc(t_cw, clk_ns)) - 1;
    return imax(imax(ns_to_cyc(t_wp, clk_ns), ns_to_cyc(t_dw, clk_ns)), imax(lead, 1));
  endfunction

  // Recovery fills the rest of the minimum write cycle.
  function automatic int wrec_cyc(input int t_wc, input int n_wp, input int clk_ns);
    return imax(1, ns_to_cyc(t_wc, clk_ns) - 1 - n_wp);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // A phase loaded with N ends in its N-th cycle.
  assign expire = (cnt == CNT_W'(1));
endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_lane_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int N_RD   = 6,
  parameter int N_TURN = 2,
  parameter int N_WP   = 4,
  parameter int N_WR   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             phase_expire,
  output phase_t           phase,
  output logic             req_ready,
  output logic             accept,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture,
  output logic             rd_done
);
  phase_t nxt;

  assign req_ready = rst_n && (phase == PH_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    nxt        = phase;
    timer_load = 1'b0;
    timer_val  = '0;
    capture    = 1'b0;
    rd_done    = 1'b0;
    case (phase)
      PH_IDLE: if (accept) begin
        nxt        = req_write ? PH_WSETUP : PH_READ;
        timer_load = 1'b1;
        timer_val  = req_write ? CNT_W'(1) : CNT_W'(N_RD);
      end
      PH_READ: if (phase_expire) begin
        nxt        = PH_TURN;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_TURN);
        capture    = 1'b1;
      end
      PH_TURN: if (phase_expire) begin
        nxt     = PH_IDLE;
        rd_done = 1'b1;
      end
      PH_WSETUP: if (phase_expire) begin
        nxt        = PH_WPULSE;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_WP);
      end
      PH_WPULSE: if (phase_expire) begin
        nxt        = PH_WREC;
        timer_load = 1'b1;
        timer_val  = CNT_W'(N_WR);
      end
      PH_WREC: if (phase_expire) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R2
  AST_TURN_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |=> (phase == PH_TURN) || (phase == PH_IDLE)); // R6
  AST_READ_PRECEDES_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TURN) |-> ($past(phase) == PH_READ) || ($past(phase) == PH_TURN)); // R6
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [LANES-1:0]   lane_en,
  input  logic [8*LANES-1:0] dq_in,
  output logic [8*LANES-1:0] data
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        data[8*g +: 8] <= '0;
      else if (capture)
        data[8*g +: 8] <= lane_en[g] ? dq_in[8*g +: 8] : 8'h00;
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int CLK_NS      = 20,
  parameter int T_RC_NS     = 120,
  parameter int T_AA_NS     = 120,
  parameter int T_OE_NS     = 60,
  parameter int T_FLOAT_NS  = 35,
  parameter int T_WC_NS     = 120,
  parameter int T_WP_NS     = 80,
  parameter int T_AW_NS     = 100,
  parameter int T_CW_NS     = 100,
  parameter int T_DW_NS     = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_be,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [15:0]       mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [15:0]       mem_dq_in
);
  localparam int LANES  = 2;
  localparam int N_RD   = imax(imax(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_AA_NS, CLK_NS)),
                               ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int N_TURN = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int N_WP   = wpulse_cyc(T_WP_NS, T_DW_NS, T_AW_NS, T_CW_NS, CLK_NS);
  localparam int N_WR   = wrec_cyc(T_WC_NS, N_WP, CLK_NS);
  localparam int N_MAX  = imax(imax(N_RD, N_TURN), imax(N_WP, N_WR));
  localparam int CNT_W  = $clog2(N_MAX + 1);

  phase_t             phase;
  logic               accept, timer_load, phase_expire, capture, rd_done;
  logic [CNT_W-1:0]   timer_val;
  logic [ADDR_W-1:0]  addr_q;
  logic [15:0]        wdata_q;
  logic [LANES-1:0]   be_q;
  logic               rd_valid_q;

  // Named phase events used by the control decode and the assertions.
  logic in_read, in_write, ext_active;
  assign in_read    = (phase == PH_READ);
  assign in_write   = (phase == PH_WSETUP) || (phase == PH_WPULSE) || (phase == PH_WREC);
  assign ext_active = in_read || in_write;

  sram_cycle_fsm #(
    .CNT_W(CNT_W), .N_RD(N_RD), .N_TURN(N_TURN), .N_WP(N_WP), .N_WR(N_WR)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .phase_expire(phase_expire), .phase(phase), .req_ready(req_ready),
    .accept(accept), .timer_load(timer_load), .timer_val(timer_val),
    .capture(capture), .rd_done(rd_done)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(timer_load), .load_val(timer_val),
    .expire(phase_expire)
  );

  sram_rd_capture #(.LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(capture), .lane_en(be_q),
    .dq_in(mem_dq_in), .data(rd_data)
  );

  // Request fields are frozen at acceptance for the whole external cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= rd_done;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
      end
    end
  end

  assign rd_valid   = rd_valid_q;
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_cs_n   = !ext_active;
  assign mem_oe_n   = !in_read;
  assign mem_we_n   = (phase != PH_WPULSE);
  assign mem_lb_n   = !(ext_active && be_q[0]);
  assign mem_ub_n   = !(ext_active && be_q[1]);
  assign mem_dq_oe  = in_write;

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n); // R9
  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n && mem_oe_n); // R9
  AST_WE_FIRST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |-> $past(mem_we_n)); // R7
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr) && $stable(mem_dq_out)); // R8
  AST_STROBES_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs_n |-> mem_ub_n && mem_lb_n); // R5
  AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_RDV_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> req_ready && mem_cs_n); // R4
  AST_TURN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> !mem_dq_oe && !req_ready); // R6
endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
  localparam int TCK = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #10 clk = ~clk;

  sram_lane_ctrl i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  typedef struct packed {
    logic [1:0]  kind;   // 0 idle, 1 read, 2 turnaround, 3 write
    logic        cs, oe, we, ub, lb, dqoe, rdy, rdv;
    logic [17:0] addr;
    logic [15:0] wd;
    logic [15:0] rd;
  } exp_t;

  exp_t        q[$];
  logic [15:0] ram [int];
  int          total = 0, bad = 0;
  bit          p_on = 0, got_acc = 0, prev_we_low = 0;
  logic        p_w;
  logic [17:0] p_a;
  logic [15:0] p_d;
  logic [1:0]  p_be;

  function automatic int cdiv(int t);
    return (t + TCK - 1) / TCK;
  endfunction
  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction

  int n_rd, n_turn, n_wp, n_wr;
  initial begin
    n_rd   = mx(mx(cdiv(120), cdiv(120)), cdiv(60));
    n_turn = cdiv(35);
    n_wp   = mx(mx(cdiv(80), cdiv(50)), mx(mx(cdiv(100), cdiv(100)) - 1, 1));
    n_wr   = mx(1, cdiv(120) - 1 - n_wp);
  end

  function automatic logic [15:0] peek(int a);
    logic [31:0] v;
    if (ram.exists(a)) return ram[a];
    v = a;
    return {v[7:0] ^ 8'hC3, v[15:8] ^ v[17:16] ^ 8'h5A};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic exp_t idle_e();
    exp_t e;
    e = '0;
    e.cs = 1; e.oe = 1; e.we = 1; e.ub = 1; e.lb = 1; e.rdy = 1;
    return e;
  endfunction

  task automatic push_req();
    exp_t e;
    logic [15:0] m;
    if (!p_w) begin
      for (int i = 0; i < n_rd; i++) begin
        e = '0; e.kind = 1; e.cs = 0; e.oe = 0; e.we = 1;
        e.ub = ~p_be[1]; e.lb = ~p_be[0]; e.addr = p_a;
        q.push_back(e);
      end
      for (int i = 0; i < n_turn; i++) begin
        e = idle_e(); e.kind = 2; e.rdy = 0;
        q.push_back(e);
      end
      m = peek(int'(p_a));
      e = idle_e(); e.rdv = 1;
      e.rd = {p_be[1] ? m[15:8] : 8'h00, p_be[0] ? m[7:0] : 8'h00};
      q.push_back(e);
    end else begin
      for (int i = 0; i < 1 + n_wp + n_wr; i++) begin
        e = '0; e.kind = 3; e.cs = 0; e.oe = 1;
        e.we = (i >= 1 && i <= n_wp) ? 1'b0 : 1'b1;
        e.ub = ~p_be[1]; e.lb = ~p_be[0]; e.dqoe = 1; e.addr = p_a; e.wd = p_d;
        q.push_back(e);
      end
    end
  endtask

  task automatic step();
    exp_t  e;
    string kt;
    logic [15:0] m;
    if (req_valid && req_ready) begin
      p_on = 1; p_w = req_write; p_a = req_addr; p_d = req_wdata; p_be = req_be;
    end
    @(negedge clk);
    if (p_on) begin push_req(); p_on = 0; got_acc = 1; end
    e  = (q.size() != 0) ? q.pop_front() : idle_e();
    kt = (e.kind == 0) ? "R1" : (e.kind == 1) ? "R3" : (e.kind == 2) ? "R6" : "R7";
    chk(mem_cs_n == e.cs,   kt, "cs_n",  {31'b0, mem_cs_n},  {31'b0, e.cs});
    chk(mem_oe_n == e.oe,   kt, "oe_n",  {31'b0, mem_oe_n},  {31'b0, e.oe});
    chk(mem_we_n == e.we,   kt, "we_n",  {31'b0, mem_we_n},  {31'b0, e.we});
    chk(mem_dq_oe == e.dqoe, kt, "dq_oe", {31'b0, mem_dq_oe}, {31'b0, e.dqoe});
    chk({mem_ub_n, mem_lb_n} == {e.ub, e.lb}, "R5", "strobes",
        {30'b0, mem_ub_n, mem_lb_n}, {30'b0, e.ub, e.lb});
    chk(req_ready == e.rdy, "R2", "ready", {31'b0, req_ready}, {31'b0, e.rdy});
    chk(rd_valid == e.rdv,  "R4", "rd_valid", {31'b0, rd_valid}, {31'b0, e.rdv});
    if (!e.cs) chk(mem_addr == e.addr, "R8", "addr", {14'b0, mem_addr}, {14'b0, e.addr});
    if (e.dqoe) chk(mem_dq_out == e.wd, "R8", "dq_out", {16'b0, mem_dq_out}, {16'b0, e.wd});
    if (e.rdv) chk(rd_data == e.rd, "R4", "rd_data", {16'b0, rd_data}, {16'b0, e.rd});
    if (mem_dq_oe && !mem_oe_n) chk(0, "R9", "bus fight", 32'd1, 32'd0);
    if (!mem_we_n && (mem_cs_n || !mem_oe_n)) chk(0, "R9", "we outside cs", 32'd1, 32'd0);
    // Behavioural RAM: the write lands when write enable returns high.
    if (prev_we_low && mem_we_n) begin
      m = peek(int'(mem_addr));
      if (!mem_lb_n) m[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) m[15:8] = mem_dq_out[15:8];
      ram[int'(mem_addr)] = m;
    end
    prev_we_low = !mem_we_n && !mem_cs_n;
    m = peek(int'(mem_addr));
    mem_dq_in[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? m[7:0]  : 8'hA5;
    mem_dq_in[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? m[15:8] : 8'hA5;
  endtask

  task automatic do_req(logic w, logic [17:0] a, logic [15:0] d, logic [1:0] be, bit keep);
    req_write = w; req_addr = a; req_wdata = d; req_be = be; req_valid = 1;
    got_acc = 0;
    while (!got_acc) step();
    if (!keep) req_valid = 0;
    while (q.size() != 0) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    req_be = '0; mem_dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step();                                  // R1 idle after reset

    do_req(1, 18'h00000, 16'h1234, 2'b11, 0);           // R7 word write
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0);           // R3 R4 word read
    chk(rd_data == 16'h1234, "R10", "word write", {16'b0, rd_data}, 32'h1234);
    do_req(1, 18'h00000, 16'hABCD, 2'b10, 0);           // upper lane only
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0);
    chk(rd_data == 16'hAB34, "R10", "upper write", {16'b0, rd_data}, 32'hAB34);
    do_req(1, 18'h00000, 16'h5566, 2'b01, 0);           // lower lane only
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0);
    chk(rd_data == 16'hAB66, "R10", "lower write", {16'b0, rd_data}, 32'hAB66);
    do_req(1, 18'h00000, 16'hFFFF, 2'b00, 0);           // no lanes
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0);
    chk(rd_data == 16'hAB66, "R10", "be 00 ignored", {16'b0, rd_data}, 32'hAB66);
    do_req(0, 18'h00000, 16'h0000, 2'b01, 0);           // R4 upper masked
    chk(rd_data == 16'h0066, "R4", "lower-only read", {16'b0, rd_data}, 32'h0066);
    do_req(0, 18'h00000, 16'h0000, 2'b10, 0);           // R4 lower masked
    chk(rd_data == 16'hAB00, "R4", "upper-only read", {16'b0, rd_data}, 32'hAB00);
    repeat (4) step();
    chk(rd_data == 16'hAB00, "R4", "rd_data held", {16'b0, rd_data}, 32'hAB00);

    // Valid held high through a read, then a write taken in the pulse cycle (R2 R6).
    do_req(0, 18'h15555, 16'h0000, 2'b11, 1);
    do_req(1, 18'h3FFFF, 16'hC3A5, 2'b11, 1);
    do_req(0, 18'h3FFFF, 16'h0000, 2'b11, 0);
    chk(rd_data == 16'hC3A5, "R8", "top address", {16'b0, rd_data}, 32'hC3A5);
    do_req(0, 18'h00000, 16'h0000, 2'b11, 0);
    chk(rd_data == 16'hAB66, "R8", "no alias at 0", {16'b0, rd_data}, 32'hAB66);
    repeat (3) step();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule